// File: doc/BRIEF.md
# Two-Pass Double-Length Subtractor with Operand Stack

This block subtracts one double-length fixed-point number from another using a single word-wide adder that is used twice, less significant word first. The subtrahend arrives on two input words (high and low). The minuend is assembled from a third input word, which supplies its low half, and from the top of a small last-in first-out stack held inside the block, which supplies its high half.

A double-length value is read as `hi * 2^(W-1) + lo[W-2:0]`. The high word is two's complement, and bit W-1 of the low word is a sign position that takes no part in the value. One operation takes four clock steps: operand capture with a stack read, an idle step, the low pass with a second stack read, and the high pass. The second stack read hands the next stack entry out on `refill_o` so the caller can reload its third working register. A one-cycle `done_o` pulse marks valid results.

Top module: `dword_stack_sub`

## Requirements
- R1: A start seen in idle is accepted on that clock edge. `done_o` is high for exactly one cycle, starting after the fourth rising edge counted from and including the accepting edge.
- R2: With `done_o` high, `{res_hi_o, res_lo_o[W-2:0]}` equals `{stack_top, min_lo_i[W-2:0]} - {sub_hi_i, sub_lo_i[W-2:0]}` modulo 2^(2W-1). The operand values are those present at the accepting edge.
- R3: Bit W-1 of `sub_lo_i` and `min_lo_i` is ignored. Bit W-1 of `res_lo_o` is 0 whenever `done_o` is high.
- R4: The high pass takes a carry-in of 1 exactly when the low minuend magnitude is at least the low subtrahend magnitude. Otherwise the borrow lowers the high result by one.
- R5: The stack holds DEPTH words. `push_i` adds `push_data_i` only when the stack is not full, no operation is running, and `start` is low. Otherwise the push is ignored. `empty_o` is high when the stack holds no entry.
- R6: Each operation pops the stack twice. The entry popped at the accepting edge is the high minuend. The entry popped in the low pass appears on `refill_o`.
- R7: A pop from an empty stack yields zero and sets `err_o`. `err_o` stays set until the next accepted start, which recomputes it.
- R8: `start` while an operation is running is ignored.
- R9: Changes on the operand inputs after the accepting edge have no effect on the result.
- R10: After reset, results and `refill_o` are zero, `done_o` and `err_o` are low, and `empty_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one subtraction |
| sub_hi_i | input | W | High word of the subtrahend |
| sub_lo_i | input | W | Low word of the subtrahend (bit W-1 ignored) |
| min_lo_i | input | W | Low word of the minuend (bit W-1 ignored) |
| push_i | input | 1 | Push request for the stack |
| push_data_i | input | W | Word to push |
| res_hi_o | output | W | High word of the difference |
| res_lo_o | output | W | Low word of the difference, sign bit cleared |
| refill_o | output | W | Entry popped during the low pass |
| done_o | output | 1 | One-cycle result-valid pulse |
| err_o | output | 1 | A pop found the stack empty |
| empty_o | output | 1 | Stack holds no entry |

## Verification
The bench builds the block with W=16, DEPTH=4 and the bit-level ripple adder. With 16-bit words, the vector table can hit the borrow and no-borrow cases, exact equality of low magnitudes, and wrap-around of the 31-bit difference using values that are easy to read. A depth of four lets a handful of pushes reach the full boundary, so an overflowing push, two full drains and both empty-pop paths are all reached in a few operations.

// File: rtl/dls_pkg.sv
package dls_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_LOW  = 2'd2,
        ST_HIGH = 2'd3
    } step_e;

    typedef struct packed {
        logic accept;
        logic low;
        logic high;
        logic busy;
    } step_ctl_t;

    function automatic logic step_pops(input step_ctl_t c);
        return c.accept | c.low;
    endfunction

endpackage

// File: rtl/dls_lifo.sv
module dls_lifo #(
    parameter int W     = 48,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] top_o,
    output logic         empty_o
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  mem_q [DEPTH];
    logic          full;
    logic          do_push;
    logic          do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign do_push = push_i && !full;
    assign do_pop  = pop_i && !empty_o;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[i] <= '0;
            end else if (do_push && cnt_q == CW'(i)) begin
                mem_q[i] <= push_data_i;
            end
        end
    end

    always_comb begin
        top_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt_q == CW'(i + 1)) top_o = mem_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (do_push && !do_pop) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (do_pop && !do_push) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R5: occupancy never exceeds the depth
    a_r5_depth_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R5: a push into a full stack leaves the occupancy unchanged
    a_r5_full_push_held: assert property (@(posedge clk) disable iff (rst)
        (full && push_i && !pop_i) |=> $stable(cnt_q));

    // R7: a pop from an empty stack keeps it empty
    a_r7_empty_pop_held: assert property (@(posedge clk) disable iff (rst)
        (empty_o && pop_i && !push_i) |=> empty_o);

endmodule

// File: rtl/dls_adder.sv
module dls_adder #(
    parameter int W      = 48,
    parameter bit RIPPLE = 1'b0
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o
);
    if (RIPPLE) begin : g_ripple
        logic [W:0] c;
        assign c[0] = cin_i;
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
            assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
        end
    end else begin : g_flat
        assign sum_o = a_i + b_i + {{(W-1){1'b0}}, cin_i};
    end
endmodule

// File: rtl/dls_seq.sv
module dls_seq
    import dls_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output step_ctl_t ctl_o,
    output logic      done_o
);
    step_e state_q;
    step_e state_d;

    always_comb begin
        ctl_o.accept = (state_q == ST_IDLE) && start;
        ctl_o.low    = (state_q == ST_LOW);
        ctl_o.high   = (state_q == ST_HIGH);
        ctl_o.busy   = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_GAP : ST_IDLE;
            ST_GAP:  state_d = ST_LOW;
            ST_LOW:  state_d = ST_HIGH;
            ST_HIGH: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_o  <= (state_q == ST_HIGH);
        end
    end

    // R1: the steps run in fixed order
    a_r1_gap_then_low: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GAP) |=> (state_q == ST_LOW));
    a_r1_low_then_high: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOW) |=> (state_q == ST_HIGH));
    a_r1_high_then_done: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HIGH) |=> (done_o && state_q == ST_IDLE));
    // R1: done lasts one cycle
    a_r1_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R8: a start during a running operation starts nothing
    a_r8_busy_start: assert property (@(posedge clk) disable iff (rst)
        (ctl_o.busy && start) |=> (state_q != ST_GAP));

endmodule

// File: rtl/dword_stack_sub.sv
module dword_stack_sub
    import dls_pkg::*;
#(
    parameter int W      = 48,
    parameter int DEPTH  = 8,
    parameter bit RIPPLE = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] sub_hi_i,
    input  logic [W-1:0] sub_lo_i,
    input  logic [W-1:0] min_lo_i,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    output logic [W-1:0] res_hi_o,
    output logic [W-1:0] res_lo_o,
    output logic [W-1:0] refill_o,
    output logic         done_o,
    output logic         err_o,
    output logic         empty_o
);
    localparam logic [W-1:0] MAG_MASK = {1'b0, {(W-1){1'b1}}};

    step_ctl_t    ctl;
    logic         stk_push;
    logic [W-1:0] stk_top;
    logic         stk_empty;

    logic [W-1:0] sh_q, sl_q, ml_q, mh_q;
    logic [W-1:0] hi_q, lo_q, refill_q;
    logic         err_q;

    logic [W-1:0] add_a, add_b, add_sum;
    logic         add_cin;

    dls_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .ctl_o  (ctl),
        .done_o (done_o)
    );

    assign stk_push = push_i && !ctl.busy && !start;

    dls_lifo #(.W(W), .DEPTH(DEPTH)) u_lifo (
        .clk         (clk),
        .rst         (rst),
        .push_i      (stk_push),
        .push_data_i (push_data_i),
        .pop_i       (step_pops(ctl)),
        .top_o       (stk_top),
        .empty_o     (stk_empty)
    );

    // Low pass: magnitudes only, complemented subtrahend, carry 1.
    // High pass: stack word plus complemented high subtrahend, carry from low sign.
    always_comb begin
        if (ctl.low) begin
            add_a   = ml_q & MAG_MASK;
            add_b   = ~sl_q & MAG_MASK;
            add_cin = 1'b1;
        end else begin
            add_a   = mh_q;
            add_b   = ~sh_q;
            add_cin = lo_q[W-1];
        end
    end

    dls_adder #(.W(W), .RIPPLE(RIPPLE)) u_adder (
        .a_i   (add_a),
        .b_i   (add_b),
        .cin_i (add_cin),
        .sum_o (add_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            sl_q     <= '0;
            ml_q     <= '0;
            mh_q     <= '0;
            hi_q     <= '0;
            lo_q     <= '0;
            refill_q <= '0;
            err_q    <= 1'b0;
        end else begin
            if (ctl.accept) begin
                sh_q  <= sub_hi_i;
                sl_q  <= sub_lo_i;
                ml_q  <= min_lo_i;
                mh_q  <= stk_top;
                err_q <= stk_empty;
            end
            if (ctl.low) begin
                lo_q     <= add_sum;
                refill_q <= stk_top;
                if (stk_empty) err_q <= 1'b1;
            end
            if (ctl.high) begin
                hi_q      <= add_sum;
                lo_q[W-1] <= 1'b0;
            end
        end
    end

    assign res_hi_o = hi_q;
    assign res_lo_o = lo_q;
    assign refill_o = refill_q;
    assign err_o    = err_q;
    assign empty_o  = stk_empty;

    logic [2*W-2:0] wide_diff;
    assign wide_diff = {mh_q, ml_q[W-2:0]} - {sh_q, sl_q[W-2:0]};

    // R2: the two-pass result matches a single wide subtraction of the captured operands
    a_r2_wide_match: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ({hi_q, lo_q[W-2:0]} == wide_diff));
    // R3: the low result sign is cleared by the time results are valid
    a_r3_lo_sign_clear: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !res_lo_o[W-1]);
    // R7: an accepting pop from an empty stack flags an error
    a_r7_err_on_accept: assert property (@(posedge clk) disable iff (rst)
        (ctl.accept && stk_empty) |=> err_o);
    // R6: an empty refill read hands out zero
    a_r6_refill_zero: assert property (@(posedge clk) disable iff (rst)
        (ctl.low && stk_empty) |=> (refill_o == '0 && err_o));

endmodule

// File: tb/dword_stack_sub_bench.sv
`timescale 1ns/1ps
module dword_stack_sub_bench;
    localparam int BW = 16;
    localparam int BD = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [BW-1:0] sub_hi_i = '0, sub_lo_i = '0, min_lo_i = '0;
    logic          push_i = 1'b0;
    logic [BW-1:0] push_data_i = '0;
    logic [BW-1:0] res_hi_o, res_lo_o, refill_o;
    logic          done_o, err_o, empty_o;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dword_stack_sub #(.W(BW), .DEPTH(BD), .RIPPLE(1'b1)) u_dword_stack_sub (
        .clk(clk), .rst(rst), .start(start),
        .sub_hi_i(sub_hi_i), .sub_lo_i(sub_lo_i), .min_lo_i(min_lo_i),
        .push_i(push_i), .push_data_i(push_data_i),
        .res_hi_o(res_hi_o), .res_lo_o(res_lo_o), .refill_o(refill_o),
        .done_o(done_o), .err_o(err_o), .empty_o(empty_o)
    );

    // fields: minuend high (stack), minuend low, subtrahend high, subtrahend low
    localparam logic [63:0] VEC [6] = '{
        64'h0003_0005_0001_0002,
        64'h0003_0002_0001_0005,
        64'h0000_0000_0000_0001,
        64'h8000_0000_7FFF_7FFF,
        64'h1234_F00F_0234_800F,
        64'h7FFF_7FFF_FFFF_7FFF
    };

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_diff(input logic [15:0] mh, ml, sh, sl);
        logic [30:0] d;
        d = {mh, ml[14:0]} - {sh, sl[14:0]};
        return {d[30:15], 1'b0, d[14:0]};
    endfunction

    task automatic push_word(input logic [15:0] v);
        push_i = 1'b1;
        push_data_i = v;
        @(negedge clk);
        push_i = 1'b0;
    endtask

    task automatic run_op(input logic [15:0] sh, sl, ml, output int lat);
        sub_hi_i = sh; sub_lo_i = sl; min_lo_i = ml;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done_o && lat < 16) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int lat;
        logic [31:0] e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk(res_hi_o == 0 && res_lo_o == 0, "R10 results zero", {res_hi_o, res_lo_o}, 0);
        chk(refill_o == 0, "R10 refill zero", 32'(refill_o), 0);
        chk(!done_o && !err_o && empty_o, "R10 flags", {29'd0, done_o, err_o, empty_o}, 1);

        // vector table: R1 R2 R3 R4 R6
        for (int v = 0; v < 6; v++) begin
            logic [15:0] mh, ml, sh, sl, rv;
            {mh, ml, sh, sl} = VEC[v];
            rv = 16'h00A0 + 16'(v);
            push_word(rv);
            push_word(mh);
            run_op(sh, sl, ml, lat);
            e = ref_diff(mh, ml, sh, sl);
            chk(lat == 4, "R1 latency", 32'(lat), 4);
            chk({res_hi_o, res_lo_o} == e, "R2 R4 difference", {res_hi_o, res_lo_o}, e);
            chk(res_lo_o[15] == 1'b0, "R3 low sign", 32'(res_lo_o), 32'(e[15:0]));
            chk(refill_o == rv, "R6 refill", 32'(refill_o), 32'(rv));
            chk(!err_o && empty_o, "R7 no error", {30'd0, err_o, empty_o}, 1);
            @(negedge clk);
            chk(!done_o, "R1 done single", 32'(done_o), 0);
        end

        // R5 full boundary: fifth push ignored
        for (int i = 1; i <= 5; i++) push_word(16'h0A00 + 16'(i));
        chk(!empty_o, "R5 not empty", 32'(empty_o), 0);
        run_op(16'h0001, 16'h0000, 16'h0000, lat);
        chk(res_hi_o == 16'h0A03, "R5 R6 top after overflow push", 32'(res_hi_o), 32'h0A03);
        chk(refill_o == 16'h0A03, "R6 second pop", 32'(refill_o), 32'h0A03);
        run_op(16'h0000, 16'h0000, 16'h0000, lat);
        chk(res_hi_o == 16'h0A02 && refill_o == 16'h0A01, "R6 drain order",
            {res_hi_o, refill_o}, 32'h0A02_0A01);
        chk(empty_o, "R5 empty after drain", 32'(empty_o), 1);

        // R7 empty pops
        run_op(16'h0000, 16'h0001, 16'h0000, lat);
        chk(err_o, "R7 err on empty", 32'(err_o), 1);
        chk({res_hi_o, res_lo_o} == 32'hFFFF_7FFF, "R7 zero operand",
            {res_hi_o, res_lo_o}, 32'hFFFF_7FFF);
        chk(refill_o == 0, "R7 refill zero", 32'(refill_o), 0);
        push_word(16'h0100);
        run_op(16'h0000, 16'h0000, 16'h0000, lat);
        chk(err_o && res_hi_o == 16'h0100, "R7 second pop empty",
            {15'd0, err_o, res_hi_o}, 32'h0001_0100);

        // R8 R9 R5: held start, changed inputs, push while busy
        push_word(16'h0B01); push_word(16'h0B02);
        push_word(16'h0C01); push_word(16'h0C02);
        sub_hi_i = 16'h0000; sub_lo_i = 16'h0000; min_lo_i = 16'h0001;
        start = 1'b1;
        @(negedge clk);
        sub_hi_i = 16'hFFFF; sub_lo_i = 16'h7FFF; min_lo_i = 16'h0000;
        push_i = 1'b1; push_data_i = 16'hDEAD;
        @(negedge clk);
        start = 1'b0; push_i = 1'b0;
        lat = 2;
        while (!done_o && lat < 16) begin @(negedge clk); lat++; end
        chk(err_o == 0, "R7 err cleared by new start", 32'(err_o), 0);
        chk(lat == 4, "R8 latency under held start", 32'(lat), 4);
        chk({res_hi_o, res_lo_o} == 32'h0C02_0001, "R9 captured operands",
            {res_hi_o, res_lo_o}, 32'h0C02_0001);
        chk(refill_o == 16'h0C01, "R6 refill busy case", 32'(refill_o), 32'h0C01);
        @(negedge clk);
        chk(!done_o, "R8 no second run", 32'(done_o), 0);
        run_op(16'h0000, 16'h0000, 16'h0000, lat);
        chk(res_hi_o == 16'h0B02 && refill_o == 16'h0B01 && !err_o,
            "R5 R8 stack untouched", {res_hi_o, refill_o}, 32'h0B02_0B01);
        chk(empty_o, "R5 busy push ignored", 32'(empty_o), 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule